// File: doc/BRIEF.md
# Rotating-Priority Switch Allocator with Crossbar

This block is the switch allocator and crossbar at the centre of a seven-port 3D mesh router. Each input port presents a request flag and a target-port code. Route computation upstream has already produced that code. The block keeps a busy flag for every output. It links a requesting input to its target output at one clock edge when that output is free. From then on it carries the input's flits and valid bit to the output, and the output's credit back to the input. The link holds until the input pulses its release line.

Fairness comes from a rotating priority. The input that was granted most recently drops to the lowest rank. The input that follows it in port order moves up to the highest rank. A design-time parameter selects the arbiter. The serial variant examines one input per cycle, cycling through the ports, so an input whose target is free can wait up to seven cycles. The parallel variant evaluates every input in the same cycle, so an input waits only while its target is busy. Ports are indexed 0 to 6 (East, West, North, South, Top, Bottom, Local). Port 0 holds the highest rank after reset.

Top module: `rr_switch_alloc`

## Requirements
- R1: After reset, no output is busy and no input is linked. Every output drives valid low and every input sees its credit low. Under contention, input 0 has the highest rank.
- R2: An input is granted only when its request flag is high, its code is below NPORT, and the coded output is not busy. A code of 7 (with NPORT = 7) never produces a link.
- R3: A granted input shows as linked right after the clock edge at which it is granted. In parallel mode this is the first edge after the request appears with a free target. From that point the output carries that input's flit, and the output's valid equals the input's valid.
- R4: Serial mode examines one input per cycle: input 0 at the first edge after reset, then 1, 2 and so on through 6, wrapping back to 0. A lone request from input i, raised d edges after reset with a free target, is linked after ((i − d) mod 7) + 1 edges. At most one grant occurs per edge.
- R5: In parallel mode, inputs that target different free outputs are all granted at the same edge.
- R6: When several inputs want the same free output at one edge in parallel mode, the winner is the first requester in the order L+1, L+2, … (mod 7). Here L is the input granted most recently. L itself therefore ranks last.
- R7: An output stays busy from its grant until the edge at which its owner's release is seen. It is free right after that edge and can be granted at the next one.
- R8: A request whose target is busy is kept. It is granted at the first edge at which the target is free.
- R9: An output with no link drives valid low. A linked input's credit equals the credit of its linked output. An unlinked input's credit is low.
- R10: A request from an input that is already linked is ignored, and so is a release from an input that is not linked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | NPORT | Per-input request flag |
| req_tgt | input | NPORT*TW | Per-input target-port code, TW bits each |
| req_rel | input | NPORT | Per-input release pulse, ends the input's link |
| in_flit | input | NPORT*FLIT_W | Per-input flit data |
| in_vld | input | NPORT | Per-input flit valid |
| in_credit | output | NPORT | Credit returned to each input from its linked output |
| in_linked | output | NPORT | Input currently holds an output |
| out_flit | output | NPORT*FLIT_W | Per-output flit data |
| out_vld | output | NPORT | Per-output flit valid |
| out_credit | input | NPORT | Credit arriving at each output from downstream |
| out_busy | output | NPORT | Output currently held by an input |

## Verification
The bench builds two copies of the block side by side. Both have seven ports and eight-bit flits; one uses the parallel arbiter and the other the serial one. Seven ports keep the full rotation small. The bench can sweep every last-winner position against all 127 non-empty sets of inputs contending for one output. It can also sweep every serial scan phase against every requesting input. Targeted sequences cover the remaining behaviour: holding a request against a busy output, the release timing, credit steering, and the ignored requests and releases.

// File: rtl/swa_pkg.sv
package swa_pkg;

   // position reached by stepping 'step' places round a ring of 'n' ports
   function automatic int unsigned ring_step(input int unsigned base,
                                             input int unsigned step,
                                             input int unsigned n);
      return (base + step) % n;
   endfunction

endpackage

// File: rtl/swa_central.sv
module swa_central #(
   parameter int unsigned NPORT = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPORT-1:0] elig_i,
   output logic [NPORT-1:0] gnt_o
);
   localparam int unsigned SW = (NPORT > 1) ? $clog2(NPORT) : 1;

   generate
      if (NPORT < 2) begin : g_bad_cfg
         $error("swa_central needs at least two ports");
      end
   endgenerate

   logic [SW-1:0] scan_q;

   // only the port under the scan pointer may win this cycle
   always_comb begin
      gnt_o         = '0;
      gnt_o[scan_q] = elig_i[scan_q];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scan_q <= '0;
      end else if (scan_q == SW'(NPORT - 1)) begin
         scan_q <= '0;
      end else begin
         scan_q <= scan_q + 1'b1;
      end
   end

endmodule

// File: rtl/swa_parallel.sv
module swa_parallel
   import swa_pkg::*;
#(
   parameter int unsigned NPORT = 7,
   parameter int unsigned TW    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NPORT-1:0]    elig_i,
   input  logic [NPORT*TW-1:0] tgt_i,
   output logic [NPORT-1:0]    gnt_o
);
   generate
      if (NPORT < 2 || NPORT > (1 << TW)) begin : g_bad_cfg
         $error("swa_parallel: NPORT does not fit the code width");
      end
   endgenerate

   logic [TW-1:0] last_q;
   logic [TW-1:0] last_d;

   // each output takes the first eligible requester after the last winner
   always_comb begin
      int unsigned idx;
      logic        taken;
      gnt_o = '0;
      idx   = 0;
      taken = 1'b0;
      for (int o = 0; o < NPORT; o++) begin
         taken = 1'b0;
         for (int k = 0; k < NPORT; k++) begin
            idx = ring_step(32'(last_q) + 1, k, NPORT);
            if (!taken && elig_i[idx] && tgt_i[idx*TW +: TW] == TW'(o)) begin
               gnt_o[idx] = 1'b1;
               taken      = 1'b1;
            end
         end
      end
      // the winner furthest along the ring becomes the new lowest rank
      last_d = last_q;
      for (int k = 0; k < NPORT; k++) begin
         idx = ring_step(32'(last_q) + 1, k, NPORT);
         if (gnt_o[idx]) last_d = TW'(idx);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= TW'(NPORT - 1);
      else        last_q <= last_d;
   end

   // R6: the recorded last winner is always a port granted at the previous edge
   a_r6_last_is_winner : assert property (@(posedge clk) disable iff (!rst_n)
      (|gnt_o) |=> (last_q == $past(last_d)));

endmodule

// File: rtl/swa_xbar.sv
module swa_xbar #(
   parameter int unsigned NPORT  = 7,
   parameter int unsigned TW     = 3,
   parameter int unsigned FLIT_W = 16
) (
   input  logic [NPORT*FLIT_W-1:0] in_flit_i,
   input  logic [NPORT-1:0]        in_vld_i,
   input  logic [NPORT-1:0]        out_credit_i,
   input  logic [NPORT-1:0]        busy_i,
   input  logic [NPORT*TW-1:0]     owner_i,
   input  logic [NPORT-1:0]        linked_i,
   input  logic [NPORT*TW-1:0]     lport_i,
   output logic [NPORT*FLIT_W-1:0] out_flit_o,
   output logic [NPORT-1:0]        out_vld_o,
   output logic [NPORT-1:0]        in_credit_o
);
   generate
      for (genvar o = 0; o < NPORT; o++) begin : g_out
         logic [TW-1:0] src;
         assign src = owner_i[o*TW +: TW];
         assign out_vld_o[o] = busy_i[o] && in_vld_i[src];
         assign out_flit_o[o*FLIT_W +: FLIT_W] =
            busy_i[o] ? in_flit_i[32'(src)*FLIT_W +: FLIT_W] : '0;
      end
      for (genvar i = 0; i < NPORT; i++) begin : g_in
         logic [TW-1:0] dst;
         assign dst = lport_i[i*TW +: TW];
         assign in_credit_o[i] = linked_i[i] && out_credit_i[dst];
      end
   endgenerate

endmodule

// File: rtl/rr_switch_alloc.sv
module rr_switch_alloc #(
   parameter int unsigned NPORT    = 7,
   parameter int unsigned FLIT_W   = 16,
   parameter bit          PARALLEL = 1'b1,
   localparam int unsigned TW      = (NPORT > 1) ? $clog2(NPORT) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NPORT-1:0]        req_vld,
   input  logic [NPORT*TW-1:0]     req_tgt,
   input  logic [NPORT-1:0]        req_rel,
   input  logic [NPORT*FLIT_W-1:0] in_flit,
   input  logic [NPORT-1:0]        in_vld,
   output logic [NPORT-1:0]        in_credit,
   output logic [NPORT-1:0]        in_linked,
   output logic [NPORT*FLIT_W-1:0] out_flit,
   output logic [NPORT-1:0]        out_vld,
   input  logic [NPORT-1:0]        out_credit,
   output logic [NPORT-1:0]        out_busy
);
   localparam int unsigned NCODE = 1 << TW;

   generate
      if (NPORT < 2 || FLIT_W < 1) begin : g_bad_cfg
         $error("rr_switch_alloc: unsupported port count or flit width");
      end
   endgenerate

   logic [TW-1:0]       tgt      [NPORT];
   logic [NPORT-1:0]    linked_q;
   logic [TW-1:0]       lport_q  [NPORT];
   logic [NPORT-1:0]    busy_q;
   logic [TW-1:0]       owner_q  [NPORT];
   logic [NCODE-1:0]    busy_ext;
   logic [NPORT-1:0]    elig;
   logic [NPORT-1:0]    gnt;
   logic [NPORT-1:0]    rel_ok;
   logic [NPORT-1:0]    free_now;
   logic [NPORT-1:0]    hit      [NPORT];
   logic [NPORT*TW-1:0] owner_flat;
   logic [NPORT*TW-1:0] lport_flat;

   // request qualification
   always_comb begin
      busy_ext              = '0;
      busy_ext[NPORT-1:0]   = busy_q;
      for (int i = 0; i < NPORT; i++) begin
         tgt[i]    = req_tgt[i*TW +: TW];
         elig[i]   = req_vld[i] && !linked_q[i] &&
                     (tgt[i] <= TW'(NPORT - 1)) && !busy_ext[tgt[i]];
         rel_ok[i] = req_rel[i] && linked_q[i];
      end
   end

   // per-output view of grants and releases
   always_comb begin
      for (int o = 0; o < NPORT; o++) begin
         free_now[o] = busy_q[o] && rel_ok[owner_q[o]];
         for (int i = 0; i < NPORT; i++) begin
            hit[o][i] = gnt[i] && (tgt[i] == TW'(o));
         end
      end
   end

   // arbiter variant chosen at design time
   generate
      if (PARALLEL) begin : g_par
         swa_parallel #(.NPORT(NPORT), .TW(TW)) u_alloc (
            .clk    (clk),
            .rst_n  (rst_n),
            .elig_i (elig),
            .tgt_i  (req_tgt),
            .gnt_o  (gnt)
         );
      end else begin : g_cen
         swa_central #(.NPORT(NPORT)) u_alloc (
            .clk    (clk),
            .rst_n  (rst_n),
            .elig_i (elig),
            .gnt_o  (gnt)
         );
      end
   endgenerate

   // link and ownership state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         linked_q <= '0;
         busy_q   <= '0;
         for (int i = 0; i < NPORT; i++) begin
            lport_q[i] <= '0;
            owner_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < NPORT; i++) begin
            if (rel_ok[i]) begin
               linked_q[i] <= 1'b0;
            end else if (gnt[i]) begin
               linked_q[i] <= 1'b1;
               lport_q[i]  <= tgt[i];
            end
         end
         for (int o = 0; o < NPORT; o++) begin
            if (free_now[o]) begin
               busy_q[o] <= 1'b0;
            end else if (|hit[o]) begin
               busy_q[o] <= 1'b1;
               for (int i = 0; i < NPORT; i++) begin
                  if (hit[o][i]) owner_q[o] <= TW'(i);
               end
            end
         end
      end
   end

   always_comb begin
      for (int i = 0; i < NPORT; i++) begin
         owner_flat[i*TW +: TW] = owner_q[i];
         lport_flat[i*TW +: TW] = lport_q[i];
      end
   end

   swa_xbar #(.NPORT(NPORT), .TW(TW), .FLIT_W(FLIT_W)) u_xbar (
      .in_flit_i    (in_flit),
      .in_vld_i     (in_vld),
      .out_credit_i (out_credit),
      .busy_i       (busy_q),
      .owner_i      (owner_flat),
      .linked_i     (linked_q),
      .lport_i      (lport_flat),
      .out_flit_o   (out_flit),
      .out_vld_o    (out_vld),
      .in_credit_o  (in_credit)
   );

   assign in_linked = linked_q;
   assign out_busy  = busy_q;

   // R4: the serial scanner grants at most one input per edge
   generate
      if (!PARALLEL) begin : g_cen_chk
         a_r4_one_per_edge : assert property (@(posedge clk) disable iff (!rst_n)
            $countones(gnt) <= 1);
      end
   endgenerate

   generate
      for (genvar i = 0; i < NPORT; i++) begin : g_in_chk
         // R2: a grant needs a live request from an input that holds nothing
         a_r2_grant_needs_req : assert property (@(posedge clk) disable iff (!rst_n)
            gnt[i] |-> (req_vld[i] && !in_linked[i]));
         // R3: a granted input appears linked after the edge
         a_r3_link_follows : assert property (@(posedge clk) disable iff (!rst_n)
            gnt[i] |=> in_linked[i]);
      end
      for (genvar o = 0; o < NPORT; o++) begin : g_out_chk
         // R6: never two winners for one output
         a_r6_single_winner : assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(hit[o]));
         // R7: an owned output stays busy until its owner releases
         a_r7_busy_hold : assert property (@(posedge clk) disable iff (!rst_n)
            (out_busy[o] && !free_now[o]) |=> out_busy[o]);
         // R9: an idle output never shows valid
         a_r9_idle_quiet : assert property (@(posedge clk) disable iff (!rst_n)
            !out_busy[o] |-> !out_vld[o]);
      end
   endgenerate

endmodule

// File: tb/rr_switch_alloc_tb.sv
module rr_switch_alloc_tb;
   localparam int N  = 7;
   localparam int FW = 8;
   localparam int TW = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    req_vld = '0;
   logic [N*TW-1:0] req_tgt = '0;
   logic [N-1:0]    req_rel = '0;
   logic [N*FW-1:0] in_flit;
   logic [N-1:0]    in_vld = '1;
   logic [N-1:0]    out_credit = '0;

   logic [N-1:0]    cr_p, lk_p, ov_p, bz_p;
   logic [N*FW-1:0] of_p;
   logic [N-1:0]    cr_c, lk_c, ov_c, bz_c;
   logic [N*FW-1:0] of_c;

   int errors = 0;
   int checks = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   rr_switch_alloc #(.NPORT(N), .FLIT_W(FW), .PARALLEL(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_tgt(req_tgt),
      .req_rel(req_rel), .in_flit(in_flit), .in_vld(in_vld),
      .in_credit(cr_p), .in_linked(lk_p), .out_flit(of_p), .out_vld(ov_p),
      .out_credit(out_credit), .out_busy(bz_p));

   rr_switch_alloc #(.NPORT(N), .FLIT_W(FW), .PARALLEL(1'b0)) u_dut_cen (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_tgt(req_tgt),
      .req_rel(req_rel), .in_flit(in_flit), .in_vld(in_vld),
      .in_credit(cr_c), .in_linked(lk_c), .out_flit(of_c), .out_vld(ov_c),
      .out_credit(out_credit), .out_busy(bz_c));

   initial begin
      for (int i = 0; i < N; i++) in_flit[i*FW +: FW] = 8'hA0 + 8'(i);
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_tgt(input int i, input int t);
      req_tgt[i*TW +: TW] = 3'(t);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n   = 1'b0;
      req_vld = '0;
      req_rel = '0;
      req_tgt = '0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset state, both variants
      out_credit = '1;
      do_reset();
      check(bz_p == 0 && lk_p == 0 && ov_p == 0 && cr_p == 0, "R1 parallel idle",
            {bz_p, lk_p, ov_p, cr_p}, 0);
      check(bz_c == 0 && lk_c == 0 && ov_c == 0 && cr_c == 0, "R1 serial idle",
            {bz_c, lk_c, ov_c, cr_c}, 0);
      out_credit = '0;

      // R1/R6: after reset every input wants output 3, input 0 wins
      for (int i = 0; i < N; i++) set_tgt(i, 3);
      req_vld = '1;
      @(negedge clk);
      check(lk_p == 7'b0000001, "R1 first rank after reset", lk_p, 1);

      // R6: sweep last winner L against every contending set for output 3
      for (int L = 0; L < N; L++) begin
         for (int m = 1; m < (1 << N); m++) begin
            int w;
            do_reset();
            req_vld[L] = 1'b1;
            set_tgt(L, 5);
            @(negedge clk);
            req_vld    = '0;
            req_rel[L] = 1'b1;
            @(negedge clk);
            req_rel = '0;
            for (int i = 0; i < N; i++) set_tgt(i, 3);
            req_vld = 7'(m);
            @(negedge clk);
            w = -1;
            for (int k = 0; k < N; k++) begin
               int idx;
               idx = (L + 1 + k) % N;
               if (w < 0 && m[idx]) w = idx;
            end
            check(lk_p == 7'(1 << w) && of_p[3*FW +: FW] == 8'hA0 + 8'(w) && ov_p[3],
                  "R6 rotating winner", {lk_p, of_p[3*FW +: FW]}, {7'(1 << w), 8'hA0 + 8'(w)});
         end
      end

      // R4: serial scan phase d against requesting input i; R3 parallel one edge
      for (int d = 0; d < N; d++) begin
         for (int i = 0; i < N; i++) begin
            int n;
            int exp_n;
            do_reset();
            repeat (d) @(negedge clk);
            req_vld[i] = 1'b1;
            set_tgt(i, (i + 1) % N);
            n = 0;
            @(negedge clk);
            n = 1;
            check(lk_p[i] == 1'b1, "R3 parallel one-edge grant", lk_p, 7'(1 << i));
            while (!lk_c[i] && n < 10) begin
               @(negedge clk);
               n++;
            end
            exp_n = ((i - d + N) % N) + 1;
            check(n == exp_n, "R4 serial wait", n, exp_n);
         end
      end

      // R5 and R4: all inputs to distinct free outputs
      do_reset();
      for (int i = 0; i < N; i++) set_tgt(i, (i + 1) % N);
      req_vld = '1;
      for (int k = 1; k <= N; k++) begin
         @(negedge clk);
         if (k == 1) check(lk_p == 7'h7F, "R5 all granted in one edge", lk_p, 7'h7F);
         check(lk_c == 7'((1 << k) - 1), "R4 one serial grant per edge", lk_c, (1 << k) - 1);
      end

      // R2: code 7 never links
      do_reset();
      req_vld[0] = 1'b1;
      set_tgt(0, 7);
      repeat (9) @(negedge clk);
      check(lk_p == 0 && bz_p == 0, "R2 invalid code parallel", {lk_p, bz_p}, 0);
      check(lk_c == 0 && bz_c == 0, "R2 invalid code serial", {lk_c, bz_c}, 0);

      // R7, R8, R10 on the parallel variant
      do_reset();
      req_vld[1] = 1'b1;
      set_tgt(1, 2);
      @(negedge clk);
      check(lk_p[1] && bz_p[2], "R3 link to output 2", {lk_p, bz_p}, 0);
      set_tgt(1, 5);                 // R10: new target from linked input
      req_vld[4] = 1'b1;
      set_tgt(4, 2);                 // R8: blocked requester
      for (int k = 0; k < 3; k++) begin
         req_rel[0] = (k == 1);      // R10: release from unlinked input
         @(negedge clk);
         check(!lk_p[4] && bz_p[2], "R8 blocked while busy", {lk_p, bz_p}, 0);
         check(!bz_p[5] && lk_p[1], "R10 ignored request and release", {lk_p, bz_p}, 0);
      end
      req_rel    = '0;
      req_vld[1] = 1'b0;
      req_rel[1] = 1'b1;
      @(negedge clk);
      req_rel = '0;
      check(!lk_p[1] && !lk_p[4] && !bz_p[2], "R7 free after release edge",
            {lk_p, bz_p}, 0);
      @(negedge clk);
      check(lk_p[4] && bz_p[2] && of_p[2*FW +: FW] == 8'hA4, "R8 granted once free",
            of_p[2*FW +: FW], 8'hA4);

      // R9: credit steering and valid
      out_credit = 7'b0000100;
      #1;
      check(cr_p == 7'b0010000, "R9 credit to linked input", cr_p, 7'b0010000);
      out_credit = '1;
      #1;
      check(cr_p == lk_p && cr_p == 7'b0010000, "R9 unlinked inputs see no credit", cr_p, 7'b0010000);
      in_vld[4] = 1'b0;
      #1;
      check(ov_p == 0, "R9 valid follows input", ov_p, 0);
      in_vld = '1;
      #1;
      check(ov_p == 7'b0000100, "R9 only linked output valid", ov_p, 7'b0000100);
      out_credit = '0;

      done = 1;
      summary();
      $finish;
   end

endmodule